// File: doc/BRIEF.md
# Two-Clock Shared-RAM Processor Pipeline

This block is a small processor core. Its program and its working registers live in one dual-port synchronous RAM, and there is no separate register file. Every instruction takes two clocks. The core uses the two RAM ports in a fixed alternation. On the "get" edge, one port writes the result of the instruction now executing while the other port reads the next instruction word at the program counter. On the following "operand" edge, the destination and source fields of the word that has just come back are used at once as the addresses of two operand reads. At the next get edge the two operand values and the instruction are latched together. The ALU then works on them over the two clocks that follow.

To use the core, hold reset and load program and data through the preload port. The same port can read words back while reset is held. Then release reset and the core fetches from address 0. An execute-side stall input freezes the pipeline at a get edge for as long as it is held, and the program counter is visible on a debug output.

Instruction word: opcode in bits [31:28], destination address in bits [17:9], source address in bits [8:0]. Bits [27:18] are ignored.

Top module: `tpc_core`

## Requirements
- R1: While `rst` is high, the program counter reads 0 and the preload port owns the RAM. A word written with `preWe` high can be read back by presenting its address with `preWe` low: `preRdData` shows it one clock later.
- R2: After reset is released, the first rising edge fetches address 0. With no stall and no jump, `pcView` advances by one on every second edge, so it reads floor(k/2)+1 after edge k, counting from 0.
- R3: The result of an instruction is written to the RAM word named by its destination field, bits [17:9]. The source field, bits [8:0], names the second operand.
- R4: Opcode 0 copies the source value. Opcodes 1 to 5 compute destination+source, destination−source, AND, OR and XOR respectively. Opcodes 7 to 15 write nothing.
- R5: Opcode 6 (jump) writes nothing and loads the program counter with the low 9 bits of the source operand. The instruction that follows the jump in memory is discarded and has no effect. The jump takes effect on the get edge that would otherwise write its result: the target is fetched on that edge and `pcView` shows target+1 afterwards.
- R6: An instruction that reads the destination of the instruction directly before it sees the old value. The instruction two places later sees the new value.
- R7: When `stall` is high at a get edge, that edge is held: the program counter and all latches keep their values and no RAM access is issued. The edge proceeds once `stall` is low. `stall` has no effect at an operand edge.
- R8: A result write and an instruction fetch can fall on the same edge at the same address. In that case the fetch returns the word's previous contents, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; enables the preload port |
| stall | input | 1 | Execute-side hold, sampled at get edges |
| preWe | input | 1 | Preload write enable (effective only in reset) |
| preAddr | input | ADDR_W (9) | Preload address |
| preData | input | DATA_W (32) | Preload write data |
| preRdData | output | DATA_W (32) | Preload read data, one clock after the address |
| pcView | output | ADDR_W (9) | Debug view of the program counter |

## Verification
The result writeback and the instruction fetch share the get edge on separate ports. The interesting case is when both hit the same word. The bench provokes this with a program whose first instruction overwrites the word two places ahead, since that word is fetched on exactly the edge on which the write lands. The outcome is judged in two ways: the old instruction at that address must be the one that runs, and its effect must appear in a target word. Reading the address back after reset must then return the new word. The operand reads at the operand edge collide in a similar way with the writeback of the preceding instruction, and this is judged by placing two dependent copies one and two slots behind a producer.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int DEF_DATA_W = 32;
  localparam int DEF_ADDR_W = 9;
  localparam int DEF_OP_W   = 4;

  localparam logic [3:0] OP_MOV = 4'd0;
  localparam logic [3:0] OP_ADD = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_AND = 4'd3;
  localparam logic [3:0] OP_OR  = 4'd4;
  localparam logic [3:0] OP_XOR = 4'd5;
  localparam logic [3:0] OP_JMP = 4'd6;

  typedef enum logic {
    PH_GET  = 1'b0,
    PH_OPER = 1'b1
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic preMode;   // reset held: preload owns port A
    logic getEdge;   // this edge fetches, writes back, latches operands
    logic operEdge;  // this edge reads operands, latches instruction
    logic holding;   // get edge suppressed by stall
  } strobe_t;

endpackage

// File: rtl/tpc_ram.sv
module tpc_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              aEn,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWd,
  output logic [DATA_W-1:0] aQ,
  input  logic              bEn,
  input  logic [ADDR_W-1:0] bAddr,
  output logic [DATA_W-1:0] bQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // port A: read-first, write capable
  always_ff @(posedge clk) begin
    if (aEn) begin
      if (aWe) mem[aAddr] <= aWd;
      aQ <= mem[aAddr];
    end
  end

  // port B: read only, sees pre-edge contents
  always_ff @(posedge clk) begin
    if (bEn) bQ <= mem[bAddr];
  end

endmodule

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
  import tpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stall,
  output strobe_t strb
);
  phase_e phQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      phQ <= PH_GET;
    end else if (phQ == PH_OPER) begin
      phQ <= PH_GET;
    end else if (!stall) begin
      phQ <= PH_OPER;
    end
  end

  always_comb begin
    strb.preMode  = rst;
    strb.getEdge  = !rst && (phQ == PH_GET) && !stall;
    strb.holding  = !rst && (phQ == PH_GET) && stall;
    strb.operEdge = !rst && (phQ == PH_OPER);
  end

  // R2: an operand edge is always followed by a get phase
  a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
    (phQ == PH_OPER) |=> (phQ == PH_GET));

  // R7: a stalled get phase stays in get
  a_r7_gox_hold: assert property (@(posedge clk) disable iff (rst)
    (phQ == PH_GET && stall) |=> (phQ == PH_GET));

  // R7: stall at an operand edge is ignored
  a_r7_oper_ignores_stall: assert property (@(posedge clk) disable iff (rst)
    (phQ == PH_OPER && stall) |-> strb.operEdge);

  a_r2_one_strobe: assert property (@(posedge clk)
    $onehot0({strb.getEdge, strb.operEdge, strb.holding, strb.preMode}));

endmodule

// File: rtl/tpc_dpath.sv
module tpc_dpath
  import tpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic              preWe,
  input  logic [ADDR_W-1:0] preAddr,
  input  logic [DATA_W-1:0] preData,
  output logic              aEn,
  output logic              aWe,
  output logic [ADDR_W-1:0] aAddr,
  output logic [DATA_W-1:0] aWd,
  input  logic [DATA_W-1:0] aRdata,
  output logic              bEn,
  output logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bRdata,
  output logic [ADDR_W-1:0] pcView
);
  localparam int SRC_LO = 0;
  localparam int DST_LO = ADDR_W;
  localparam int OP_LO  = DATA_W - OP_W;
  localparam int GAP_LO = 2 * ADDR_W;

  // fields of the word returning on port B
  logic [OP_W-1:0]   bOp;
  logic [ADDR_W-1:0] bDst, bSrc;
  logic              unusedGapBits;

  assign bOp  = bRdata[OP_LO +: OP_W];
  assign bDst = bRdata[DST_LO +: ADDR_W];
  assign bSrc = bRdata[SRC_LO +: ADDR_W];
  assign unusedGapBits = ^bRdata[OP_LO-1:GAP_LO];

  // pipeline state
  logic [ADDR_W-1:0] pcQ;
  logic [OP_W-1:0]   opLat, opX;
  logic [ADDR_W-1:0] dstLat, dstX;
  logic              instrValid, execValid;
  logic [DATA_W-1:0] dLat, sLat;

  // execute
  logic [DATA_W-1:0] aluOut;
  logic              writesBack, jumpNow;
  logic [ADDR_W-1:0] fetchAddr;

  always_comb begin
    case (opX)
      OP_MOV:  aluOut = sLat;
      OP_ADD:  aluOut = dLat + sLat;
      OP_SUB:  aluOut = dLat - sLat;
      OP_AND:  aluOut = dLat & sLat;
      OP_OR:   aluOut = dLat | sLat;
      OP_XOR:  aluOut = dLat ^ sLat;
      default: aluOut = '0;
    endcase
  end

  assign writesBack = execValid && (opX <= OP_XOR);
  assign jumpNow    = execValid && (opX == OP_JMP);
  assign fetchAddr  = jumpNow ? sLat[ADDR_W-1:0] : pcQ;

  // port arbitration
  always_comb begin
    aEn = 1'b0; aWe = 1'b0; aAddr = '0; aWd = '0;
    bEn = 1'b0; bAddr = '0;
    if (strb.preMode) begin
      aEn   = 1'b1;
      aWe   = preWe;
      aAddr = preAddr;
      aWd   = preData;
    end else if (strb.getEdge) begin
      aEn   = writesBack;
      aWe   = writesBack;
      aAddr = dstX;
      aWd   = aluOut;
      bEn   = 1'b1;
      bAddr = fetchAddr;
    end else if (strb.operEdge) begin
      aEn   = 1'b1;
      aAddr = bDst;
      bEn   = 1'b1;
      bAddr = bSrc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ        <= '0;
      opLat      <= '0;
      dstLat     <= '0;
      opX        <= '0;
      dstX       <= '0;
      instrValid <= 1'b0;
      execValid  <= 1'b0;
      dLat       <= '0;
      sLat       <= '0;
    end else if (strb.getEdge) begin
      pcQ       <= fetchAddr + 1'b1;
      opX       <= opLat;
      dstX      <= dstLat;
      execValid <= instrValid && !jumpNow;
      dLat      <= aRdata;
      sLat      <= bRdata;
    end else if (strb.operEdge) begin
      opLat      <= bOp;
      dstLat     <= bDst;
      instrValid <= 1'b1;
    end
  end

  assign pcView = pcQ;

  // R2: straight-line fetch steps the counter by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (strb.getEdge && !jumpNow) |=> (pcQ == $past(pcQ) + 1'b1));

  // R7: a held edge freezes counter and latches
  a_r7_stall_freeze: assert property (@(posedge clk) disable iff (rst)
    strb.holding |=> ($stable(pcQ) && $stable(dLat) && $stable(sLat)
                      && $stable(opLat) && $stable(opX)));

  // R5: jump squashes its follower and writes nothing
  a_r5_jmp_squash: assert property (@(posedge clk) disable iff (rst)
    (strb.getEdge && jumpNow) |=> !execValid);

  a_r5_jmp_no_write: assert property (@(posedge clk) disable iff (rst)
    jumpNow |-> !aWe);

  // R8: outside preload, writes happen only on get edges
  a_r8_write_get_only: assert property (@(posedge clk) disable iff (rst)
    aWe |-> strb.getEdge);

endmodule

// File: rtl/tpc_core.sv
module tpc_core
  import tpc_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int OP_W   = DEF_OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              preWe,
  input  logic [ADDR_W-1:0] preAddr,
  input  logic [DATA_W-1:0] preData,
  output logic [DATA_W-1:0] preRdData,
  output logic [ADDR_W-1:0] pcView
);
  strobe_t           strb;
  logic              aEn, aWe, bEn;
  logic [ADDR_W-1:0] aAddr, bAddr;
  logic [DATA_W-1:0] aWd, aQ, bQ;

  tpc_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .stall (stall),
    .strb  (strb)
  );

  tpc_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .preWe   (preWe),
    .preAddr (preAddr),
    .preData (preData),
    .aEn     (aEn),
    .aWe     (aWe),
    .aAddr   (aAddr),
    .aWd     (aWd),
    .aRdata  (aQ),
    .bEn     (bEn),
    .bAddr   (bAddr),
    .bRdata  (bQ),
    .pcView  (pcView)
  );

  tpc_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .aEn   (aEn),
    .aWe   (aWe),
    .aAddr (aAddr),
    .aWd   (aWd),
    .aQ    (aQ),
    .bEn   (bEn),
    .bAddr (bAddr),
    .bQ    (bQ)
  );

  assign preRdData = aQ;

endmodule

// File: tb/sim_tpc_core.sv
`timescale 1ns/1ps
module sim_tpc_core;

  logic        clk = 1'b0;
  logic        rst, stall, preWe;
  logic [8:0]  preAddr;
  logic [31:0] preData;
  logic [31:0] preRdData;
  logic [8:0]  pcView;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tpc_core u0 (
    .clk(clk), .rst(rst), .stall(stall), .preWe(preWe),
    .preAddr(preAddr), .preData(preData),
    .preRdData(preRdData), .pcView(pcView)
  );

  function automatic logic [31:0] mk(input logic [3:0] op,
                                     input logic [8:0] d,
                                     input logic [8:0] s);
    return {op, 10'b0, d, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    @(negedge clk);
    preWe = 1'b1;
    for (int i = 0; i < 512; i++) begin
      preAddr = i[8:0];
      preData = '0;
      @(negedge clk);
    end
    preWe = 1'b0;
  endtask

  task automatic loadWord(input logic [8:0] a, input logic [31:0] d);
    preAddr = a; preData = d; preWe = 1'b1;
    @(negedge clk);
    preWe = 1'b0;
  endtask

  task automatic readWord(input logic [8:0] a, output logic [31:0] d);
    preAddr = a; preWe = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = preRdData;
  endtask

  task automatic startRun();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic stopRun();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectWord(input string req, input logic [8:0] a,
                            input logic [31:0] exp);
    logic [31:0] v;
    readWord(a, v);
    chk(req, v, exp);
  endtask

  // R1: reset state and preload round trip
  task automatic testPreload();
    @(negedge clk);
    chk("R1 pc in reset", {23'b0, pcView}, 32'd0);
    loadWord(9'd300, 32'hCAFE_0001);
    loadWord(9'd301, 32'h1234_ABCD);
    expectWord("R1 readback a", 9'd300, 32'hCAFE_0001);
    expectWord("R1 readback b", 9'd301, 32'h1234_ABCD);
  endtask

  // R2 R3 R4: straight-line ALU program
  task automatic testAlu();
    logic [31:0] va, vb;
    va = 32'hF0F0_1234;
    vb = 32'h0FF0_4321;
    clearMem();
    loadWord(9'd101, va);
    for (int i = 111; i <= 116; i++) loadWord(i[8:0], vb);
    loadWord(9'd0, mk(4'd0, 9'd110, 9'd101));
    loadWord(9'd1, mk(4'd1, 9'd111, 9'd101));
    loadWord(9'd2, mk(4'd2, 9'd112, 9'd101));
    loadWord(9'd3, mk(4'd3, 9'd113, 9'd101));
    loadWord(9'd4, mk(4'd4, 9'd114, 9'd101));
    loadWord(9'd5, mk(4'd5, 9'd115, 9'd101));
    loadWord(9'd6, mk(4'd9, 9'd116, 9'd101));
    loadWord(9'd7, mk(4'd6, 9'd0, 9'd120));
    loadWord(9'd120, 32'd7);
    startRun();
    for (int k = 0; k < 6; k++) begin
      stepEdge();
      chk($sformatf("R2 pc after edge %0d", k), {23'b0, pcView},
          32'(k / 2 + 1));
    end
    repeat (40) stepEdge();
    stopRun();
    expectWord("R4 MOV", 9'd110, va);
    expectWord("R4 ADD", 9'd111, vb + va);
    expectWord("R4 SUB", 9'd112, vb - va);
    expectWord("R4 AND", 9'd113, vb & va);
    expectWord("R4 OR", 9'd114, vb | va);
    expectWord("R3 XOR to dst", 9'd115, vb ^ va);
    expectWord("R4 opcode 9 no write", 9'd116, vb);
    expectWord("R3 source untouched", 9'd101, va);
  endtask

  // R5: jump redirect and squash
  task automatic testJump();
    clearMem();
    loadWord(9'd120, 32'd20);
    loadWord(9'd121, 32'd55);
    loadWord(9'd122, 32'd21);
    loadWord(9'd130, 32'd7);
    loadWord(9'd131, 32'd7);
    loadWord(9'd132, 32'd7);
    loadWord(9'd0, mk(4'd6, 9'd130, 9'd120));
    loadWord(9'd1, mk(4'd0, 9'd130, 9'd121));
    loadWord(9'd2, mk(4'd0, 9'd131, 9'd121));
    loadWord(9'd20, mk(4'd0, 9'd132, 9'd121));
    loadWord(9'd21, mk(4'd6, 9'd0, 9'd122));
    startRun();
    repeat (3) stepEdge();
    chk("R5 pc before jump", {23'b0, pcView}, 32'd2);
    repeat (2) stepEdge();
    chk("R5 pc after jump", {23'b0, pcView}, 32'd21);
    repeat (2) stepEdge();
    chk("R5 pc at target+2", {23'b0, pcView}, 32'd22);
    repeat (30) stepEdge();
    stopRun();
    expectWord("R5 squashed follower", 9'd130, 32'd7);
    expectWord("R5 skipped word", 9'd131, 32'd7);
    expectWord("R5 target ran", 9'd132, 32'd55);
  endtask

  // R6: read-after-write distance
  task automatic testHazard();
    clearMem();
    loadWord(9'd140, 32'd10);
    loadWord(9'd141, 32'd5);
    loadWord(9'd144, 32'd3);
    loadWord(9'd0, mk(4'd1, 9'd140, 9'd141));
    loadWord(9'd1, mk(4'd0, 9'd142, 9'd140));
    loadWord(9'd2, mk(4'd0, 9'd143, 9'd140));
    loadWord(9'd3, mk(4'd6, 9'd0, 9'd144));
    startRun();
    repeat (30) stepEdge();
    stopRun();
    expectWord("R6 producer", 9'd140, 32'd15);
    expectWord("R6 next sees old", 9'd142, 32'd10);
    expectWord("R6 second sees new", 9'd143, 32'd15);
  endtask

  // R8: writeback and fetch hitting the same word on one edge
  task automatic testCollision();
    clearMem();
    loadWord(9'd150, mk(4'd0, 9'd152, 9'd151));
    loadWord(9'd151, 32'd77);
    loadWord(9'd152, 32'd1);
    loadWord(9'd153, 32'd88);
    loadWord(9'd154, 32'd2);
    loadWord(9'd156, 32'd3);
    loadWord(9'd0, mk(4'd0, 9'd2, 9'd150));
    loadWord(9'd1, mk(4'd15, 9'd155, 9'd155));
    loadWord(9'd2, mk(4'd0, 9'd154, 9'd153));
    loadWord(9'd3, mk(4'd6, 9'd0, 9'd156));
    startRun();
    repeat (30) stepEdge();
    stopRun();
    expectWord("R8 old word executed", 9'd154, 32'd88);
    expectWord("R8 new word not run", 9'd152, 32'd1);
    expectWord("R8 write landed", 9'd2, mk(4'd0, 9'd152, 9'd151));
  endtask

  // R7: stall at get edges, ignored at operand edges
  task automatic testStall();
    clearMem();
    loadWord(9'd160, 32'd3);
    loadWord(9'd161, 32'd4);
    loadWord(9'd162, 32'd1);
    loadWord(9'd163, 32'd2);
    loadWord(9'd0, mk(4'd1, 9'd160, 9'd161));
    loadWord(9'd1, mk(4'd5, 9'd162, 9'd161));
    loadWord(9'd2, mk(4'd6, 9'd0, 9'd163));
    startRun();
    repeat (2) stepEdge();
    stall = 1'b1;
    repeat (3) stepEdge();
    chk("R7 pc held", {23'b0, pcView}, 32'd1);
    stall = 1'b0;
    stepEdge();
    chk("R7 resumes", {23'b0, pcView}, 32'd2);
    stall = 1'b1;
    stepEdge();
    stall = 1'b0;
    chk("R7 oper edge pc", {23'b0, pcView}, 32'd2);
    stepEdge();
    chk("R7 oper stall ignored", {23'b0, pcView}, 32'd3);
    repeat (30) stepEdge();
    stopRun();
    expectWord("R7 add after stall", 9'd160, 32'd7);
    expectWord("R7 xor after stall", 9'd162, 32'd5);
  endtask

  initial begin
    #1_000_000;
    errs++;
    checks++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; stall = 1'b0; preWe = 1'b0;
    preAddr = '0; preData = '0;
    repeat (3) @(negedge clk);
    testPreload();
    testAlu();
    testJump();
    testHazard();
    testCollision();
    testStall();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule